// File: doc/BRIEF.md
# Key-Wakeup GPIO Port

This block is an eight-pin bidirectional port that sits on a byte-wide register bus. It holds an output latch and a per-pin direction register. It also holds a pull-up register in which each bit covers a fixed group of pins. From these it drives a tri-state pad model: an output enable, an output value and a pull-up enable for each pin. Pin levels come back through a two-flop synchronizer. Software reads the live level of input pins and the latch value of output pins at the same address.

The port also detects key-press wakeups. It takes the AND of the synchronized levels on every pin that is in input mode. When that AND drops from 1 to 0, it raises a one-cycle interrupt request. Output pins take no part in the AND. Pin 0 can also be left out of it through a control bit. If no pin counts, the AND is taken as 1 and no request can occur.

Top module: `keyport_gpio`

## Requirements
- R1: `pad_oe[i]` equals direction bit i, where 1 means output and 0 means input, and `pad_out` always carries the latch.
- R2: A read at address 0 returns, per bit, the latch for output pins and the synchronized pin level for input pins. A change on `pad_in` is visible two clock edges later.
- R3: A write to address 0 always updates the latch, also for input pins. An input pin stays undriven until its direction bit is set, and then it drives the stored value.
- R4: Pull-up register bits (address 2) map to pins as follows: bit 0 covers pin 0, bit 1 covers pin 1, bit 2 covers pins 2 and 3, and bit 3 covers pins 4 to 7. A 1 turns the pull-up on. Bits 7:4 read as 0.
- R5: A pin in output mode has `pad_pu` low whatever its pull-up bit says.
- R6: When the AND of the synchronized levels of the counted input pins falls from 1 to 0, `wake_irq` is high for exactly one cycle. That cycle is the third clock edge after the pad change.
- R7: Wakeup control bit 0 (address 3) set to 1 leaves pin 0 out of the wakeup AND. Set to 0, pin 0 is counted.
- R8: After reset, data latch, direction, pull-up and wakeup control registers all read 0x00, and `pad_oe`, `pad_out` and `pad_pu` are 0.
- R9: With no counted input pin (all outputs), no level change on the pads raises `wake_irq`.
- R10: Address 1 reads back the direction register as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| pad_in | input | 8 | Pin levels from the pads |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin output value |
| pad_pu | output | 8 | Per-pin pull-up enable |
| wake_irq | output | 1 | One-cycle wakeup request |

## Verification
The bench mixes directions with the port read, so a design that mixed up latch and pin sources would return wrong bytes on the mixed-direction vectors. Pull-up group boundaries are hit with patterns that separate pins 2–3 from 4–7. An off-by-one grouping, or a pull-up left on for output pins, shows up directly on `pad_pu`. For wakeup, the bench counts pulses after a falling pin in four cases: pin 0 counted, pin 0 excluded, pin 0 as an output, and every pin an output. A detector that looked at raw pins, ignored the exclusion bit, or held the request would give the wrong count.

// File: rtl/keyport_pkg.sv
package keyport_pkg;

   typedef enum logic [1:0] {
      KP_REG_DATA = 2'd0,
      KP_REG_DIR  = 2'd1,
      KP_REG_PULL = 2'd2,
      KP_REG_WCTL = 2'd3
   } kp_reg_e;

   localparam int KP_PULL_W = 4;

   // pull-up group covering a given pin
   function automatic int kp_pull_group(input int pin);
      if (pin < 2)      return pin;
      else if (pin < 4) return 2;
      else              return 3;
   endfunction

endpackage

// File: rtl/keyport_sync.sv
module keyport_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] d_sync
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("keyport_sync needs at least two stages");
      end
   endgenerate

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
      end else begin
         stage_q[0] <= d_in;
         for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      end
   end

   assign d_sync = stage_q[STAGES-1];
endmodule

// File: rtl/keyport_regs.sv
module keyport_regs
   import keyport_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [1:0]           bus_addr,
   input  logic                 bus_wr,
   input  logic [DATA_W-1:0]    bus_wdata,
   input  logic [DATA_W-1:0]    pin_sync,
   output logic [DATA_W-1:0]    bus_rdata,
   output logic [DATA_W-1:0]    latch_q,
   output logic [DATA_W-1:0]    dir_q,
   output logic [KP_PULL_W-1:0] pull_q,
   output logic                 excl_q
);
   localparam int PAD_W = DATA_W - KP_PULL_W;

   generate
      if (DATA_W <= KP_PULL_W) begin : g_bad_width
         $error("keyport_regs data width too small for pull-up field");
      end
   endgenerate

   kp_reg_e sel;
   assign sel = kp_reg_e'(bus_addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= '0;
         dir_q   <= '0;
         pull_q  <= '0;
         excl_q  <= 1'b0;
      end else if (bus_wr) begin
         unique case (sel)
            KP_REG_DATA: latch_q <= bus_wdata;
            KP_REG_DIR:  dir_q   <= bus_wdata;
            KP_REG_PULL: pull_q  <= bus_wdata[KP_PULL_W-1:0];
            KP_REG_WCTL: excl_q  <= bus_wdata[0];
         endcase
      end
   end

   always_comb begin
      unique case (sel)
         KP_REG_DATA: bus_rdata = (latch_q & dir_q) | (pin_sync & ~dir_q);
         KP_REG_DIR:  bus_rdata = dir_q;
         KP_REG_PULL: bus_rdata = {{PAD_W{1'b0}}, pull_q};
         KP_REG_WCTL: bus_rdata = {{(DATA_W-1){1'b0}}, excl_q};
      endcase
   end

   // R3
   latch_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 2'd0) |=> latch_q == $past(bus_wdata));
   // R10
   dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 2'd1) |=> dir_q == $past(bus_wdata));
   // R4
   pull_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 2'd2) |=> pull_q == $past(bus_wdata[KP_PULL_W-1:0]));
   // R10
   dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_addr == 2'd1) |=> $stable(dir_q));
endmodule

// File: rtl/keyport_wake.sv
module keyport_wake #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] pin_sync,
   input  logic [WIDTH-1:0] dir_q,
   input  logic             excl_q,
   output logic             wake_irq
);
   logic [WIDTH-1:0] counted;
   logic             and_now;
   logic             and_prev;

   // a pin that does not count reads as 1 in the AND
   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_pin
         if (i == 0) begin : g_first
            assign counted[i] = pin_sync[i] | dir_q[i] | excl_q;
         end else begin : g_rest
            assign counted[i] = pin_sync[i] | dir_q[i];
         end
      end
   endgenerate

   assign and_now = &counted;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         and_prev <= 1'b0;
         wake_irq <= 1'b0;
      end else begin
         and_prev <= and_now;
         wake_irq <= and_prev & ~and_now;
      end
   end

   // R6
   irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake_irq |=> !wake_irq);
   // R9
   no_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (&dir_q) |=> !wake_irq);
   // R6
   high_and_chk: assert property (@(posedge clk) disable iff (!rst_n)
      and_now |=> !wake_irq);
endmodule

// File: rtl/keyport_gpio.sv
module keyport_gpio
   import keyport_pkg::*;
#(
   parameter int PIN_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       bus_addr,
   input  logic             bus_wr,
   input  logic [PIN_W-1:0] bus_wdata,
   output logic [PIN_W-1:0] bus_rdata,
   input  logic [PIN_W-1:0] pad_in,
   output logic [PIN_W-1:0] pad_oe,
   output logic [PIN_W-1:0] pad_out,
   output logic [PIN_W-1:0] pad_pu,
   output logic             wake_irq
);
   generate
      if (PIN_W != 8) begin : g_bad_pins
         $error("keyport_gpio pull-up grouping is defined for eight pins");
      end
   endgenerate

   logic [PIN_W-1:0]     pin_sync;
   logic [PIN_W-1:0]     latch_q;
   logic [PIN_W-1:0]     dir_q;
   logic [KP_PULL_W-1:0] pull_q;
   logic                 excl_q;

   keyport_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_in(pad_in), .d_sync(pin_sync));

   keyport_regs #(.DATA_W(PIN_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .pin_sync(pin_sync), .bus_rdata(bus_rdata),
      .latch_q(latch_q), .dir_q(dir_q), .pull_q(pull_q), .excl_q(excl_q));

   keyport_wake #(.WIDTH(PIN_W)) u_wake (
      .clk(clk), .rst_n(rst_n), .pin_sync(pin_sync), .dir_q(dir_q),
      .excl_q(excl_q), .wake_irq(wake_irq));

   assign pad_oe  = dir_q;
   assign pad_out = latch_q;

   generate
      for (genvar i = 0; i < PIN_W; i++) begin : g_pull
         localparam int GRP = kp_pull_group(i);
         assign pad_pu[i] = pull_q[GRP] & ~dir_q[i];
      end
   endgenerate

   // R5
   pu_off_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_pu & pad_oe) == '0);
   // R1
   oe_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> $stable(pad_oe));
endmodule

// File: tb/keyport_gpio_test.sv
module keyport_gpio_test;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic [7:0] pad_in = 8'hFF;
   logic [7:0] pad_oe, pad_out, pad_pu;
   logic       wake_irq;

   int tests = 0;
   int fails = 0;
   int pulses = 0;
   int widest = 0;
   int run_len = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   keyport_gpio uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
      .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu), .wake_irq(wake_irq));

   always @(negedge clk) begin
      if (wake_irq) begin
         run_len++;
         if (run_len == 1) pulses++;
         if (run_len > widest) widest = run_len;
      end else begin
         run_len = 0;
      end
   end

   // {dir, latch, pull[3:0], pin, expected read, expected pad_pu}
   localparam logic [43:0] VEC [6] = '{
      44'h00_FF_F_5A_5A_FF,
      44'hFF_3C_F_00_3C_00,
      44'hF0_A5_5_0F_AF_0D,
      44'h0F_C3_A_96_93_F0,
      44'h55_00_C_FF_AA_A8,
      44'hAA_FF_3_00_AA_01
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // set pins high and quiet, clear the pulse count, apply a new pin value
   task automatic wake_try(input logic [7:0] newpin, input string req, input int exp_pulses);
      pad_in = 8'hFF;
      settle(5);
      pulses = 0; widest = 0;
      pad_in = newpin;
      settle(7);
      check(req, 8'(pulses), 8'(exp_pulses));
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 20000);
      fails++; tests++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin : main
      logic [7:0] r;
      settle(2);
      rst_n = 1'b1;
      settle(3);

      // R8 reset state
      check("R8 pad_oe", pad_oe, 8'h00);
      check("R8 pad_out", pad_out, 8'h00);
      check("R8 pad_pu", pad_pu, 8'h00);
      rd_reg(2'd1, r); check("R8 dir reg", r, 8'h00);
      rd_reg(2'd2, r); check("R8 pull reg", r, 8'h00);
      rd_reg(2'd3, r); check("R8 wake ctl reg", r, 8'h00);
      rd_reg(2'd0, r); check("R8/R2 all-input read", r, 8'hFF);

      // table walk: R1 R2 R4 R5 R10
      for (int v = 0; v < 6; v++) begin
         wr_reg(2'd1, VEC[v][43:36]);
         wr_reg(2'd0, VEC[v][35:28]);
         wr_reg(2'd2, {4'h0, VEC[v][27:24]});
         pad_in = VEC[v][23:16];
         settle(3);
         check("R1 pad_oe", pad_oe, VEC[v][43:36]);
         check("R1 pad_out", pad_out, VEC[v][35:28]);
         check("R4/R5 pad_pu", pad_pu, VEC[v][7:0]);
         rd_reg(2'd0, r); check("R2 port read", r, VEC[v][15:8]);
         rd_reg(2'd1, r); check("R10 dir read", r, VEC[v][43:36]);
      end

      // R4 upper pull-up bits read as zero
      wr_reg(2'd2, 8'hF5);
      rd_reg(2'd2, r); check("R4 pull upper bits", r, 8'h05);

      // R2 synchronizer latency: two edges
      wr_reg(2'd1, 8'h00);
      pad_in = 8'h00; settle(3);
      @(negedge clk); pad_in = 8'h3C;
      @(posedge clk); #1 bus_addr = 2'd0; #1 check("R2 one edge old", bus_rdata, 8'h00);
      @(posedge clk); #1 check("R2 two edges new", bus_rdata, 8'h3C);

      // R3 latch write on input pins
      wr_reg(2'd1, 8'h00);
      wr_reg(2'd0, 8'hA6);
      check("R3 input pins undriven", pad_oe, 8'h00);
      wr_reg(2'd1, 8'hFF);
      check("R3 latch driven", pad_out, 8'hA6);
      rd_reg(2'd0, r); check("R3 latch read", r, 8'hA6);

      // R6 wakeup, pin 0 counted
      wr_reg(2'd1, 8'h00);
      wr_reg(2'd3, 8'h00);
      wake_try(8'hFE, "R6 pin0 fall pulses", 1);
      check("R6 pulse width", 8'(widest), 8'd1);
      wake_try(8'hEF, "R6 pin4 fall pulses", 1);

      // R6 exact timing: high on the third edge after the change
      pad_in = 8'hFF; settle(5);
      pad_in = 8'hF7;
      @(posedge clk); #1 check("R6 edge1 low", {7'd0, wake_irq}, 8'd0);
      @(posedge clk); #1 check("R6 edge2 low", {7'd0, wake_irq}, 8'd0);
      @(posedge clk); #1 check("R6 edge3 high", {7'd0, wake_irq}, 8'd1);
      @(posedge clk); #1 check("R6 edge4 low", {7'd0, wake_irq}, 8'd0);

      // R7 exclusion of pin 0
      wr_reg(2'd3, 8'h01);
      wake_try(8'hFE, "R7 excluded pin0 no pulse", 0);
      wake_try(8'hFD, "R7 pin1 still counted", 1);
      wr_reg(2'd3, 8'h00);

      // output pins do not count
      wr_reg(2'd1, 8'h01);
      wake_try(8'hFE, "R6 output pin0 ignored", 0);

      // R9 no input pins
      wr_reg(2'd1, 8'hFF);
      wake_try(8'h00, "R9 all outputs no pulse", 0);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule